// File: doc/BRIEF.md
# Word-Oriented March Memory Test Sequencer

This block is a built-in self-test controller for a synchronous single-port RAM of 2^ADDR_W words, each DATA_W bits wide. On a start pulse it walks the RAM through one of three March algorithms, driving address, write data, write enable and read enable one operation per clock. It compares every word read back against the value the algorithm expects.

Three algorithms are available: March Y, March LR on all-0/all-1 data, and March LR extended with a set of background words. The backgrounds sensitise faults between bits of the same word. A sticky fail flag and the address of the first mismatching read are held until the next start. A one-cycle done pulse marks the point where both are final. The run length is fixed by the algorithm and the memory geometry, so the bench can check it against a closed formula.

Top module: `march_bist_ctrl`

## Requirements
- R1: `alg_sel` is sampled at the clock edge where `start` is seen while idle: 0 selects March Y, 1 selects March LR, 2 or 3 selects March LR with backgrounds. `start` and `alg_sel` have no effect while a test is running.
- R2: March Y runs w0 (ascending); ascending (r0,w1,r1); descending (r1,w0,r0); ascending (r0). That is 8N operations per run: 3N writes and 5N reads. It leaves every word at all-zero.
- R3: March LR runs w0 (ascending); descending (r0,w1); ascending (r1,w0,r0,r0,w1); ascending (r1,w0); ascending (r0,w1,r1,r1,w0); ascending (r0). That is 16N operations: 7N writes and 9N reads.
- R4: With backgrounds, let NB = ceil(log2 DATA_W). Background b (1..NB) has bit j equal to bit b-1 of the index j, and background 0 is all-zero. After the first five March LR elements, each b runs two ascending elements: (r bg(b-1), w bg b, w ~bg b, r ~bg b), then (r ~bg b, w bg b, r bg b). One final ascending (r bg NB) follows. The total is (16+7·NB)·N operations, the RAM ends holding bg NB, and a short between two bits of one word that plain March LR misses is reported.
- R5: Ascending elements visit addresses 0 to N-1 and descending elements visit N-1 down to 0. All operations of an element are applied to one address before the next address.
- R6: While running, exactly one of `mem_we`/`mem_re` is high every cycle; both are low when idle. During a read, `mem_wdata` carries the expected word. Read data is compared on the clock edge that follows the cycle after the read request.
- R7: Any mismatch sets `fail`, which stays set until the next accepted start. `fail_addr` holds the address of the first mismatch of the run. Both clear on an accepted start.
- R8: `done` is high for exactly one cycle, ops·N+1 clock edges after the edge that accepted start. `fail` and `fail_addr` are final at that point.
- R9: After reset, `done`, `fail`, `mem_we` and `mem_re` are low and `fail_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a test when idle |
| alg_sel | input | 2 | algorithm choice, sampled with start |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | write data, or expected data during a read |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after a read |
| done | output | 1 | one-cycle end-of-test pulse |
| fail | output | 1 | sticky mismatch flag |
| fail_addr | output | ADDR_W | address of the first mismatch |

## Verification
The bench runs all four selector codes on a fault-free 16×8 RAM model. For each run it counts writes, reads and clock edges against the formulas and checks the final contents. Samples taken at element boundaries separate ascending from descending order and show the first background word. A stuck-at bit separates detection from a clean pass. Two inter-word coupling faults, with the aggressor below and above the victim, show that each direction of address travel catches a different case. An intra-word bit short passes plain March LR but is flagged at its address once backgrounds run, which isolates the background logic. A clean run after a failing one shows that the flags clear on start.

// File: rtl/march_pkg.sv
package march_pkg;
    localparam int BG_IDX_W = 5;

    localparam logic [1:0] ALG_MARCH_Y = 2'd0;
    localparam logic [1:0] ALG_LR      = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_e;
endpackage

// File: rtl/march_elem_decode.sv
module march_elem_decode
    import march_pkg::*;
#(
    parameter int ELEM_W = 4,
    parameter int NBG    = 3
) (
    input  logic [1:0]          alg_i,
    input  logic [ELEM_W-1:0]   elem_i,
    input  logic [2:0]          op_i,
    output logic [2:0]          len_o,
    output logic                desc_o,
    output logic                last_o,
    output logic                wr_o,
    output logic                inv_o,
    output logic [BG_IDX_W-1:0] bg_o
);
    // fixed elements: bit i of wrm = op i writes, bit i of valm = op i uses all-ones
    logic [7:0] wrm, valm;
    logic       tab;
    int         k, pr;

    always_comb begin
        len_o  = 3'd1;
        desc_o = 1'b0;
        last_o = 1'b0;
        wr_o   = 1'b0;
        inv_o  = 1'b0;
        bg_o   = '0;
        wrm    = '0;
        valm   = '0;
        tab    = 1'b1;
        k      = int'(elem_i) - 5;
        pr     = k / 2;
        if (alg_i == ALG_MARCH_Y) begin
            case (int'(elem_i))
                0: wrm = 8'b0000_0001;
                1: begin len_o = 3'd3; wrm = 8'b0000_0010; valm = 8'b0000_0110; end
                2: begin len_o = 3'd3; desc_o = 1'b1; wrm = 8'b0000_0010; valm = 8'b0000_0001; end
                default: last_o = 1'b1;
            endcase
        end else if (int'(elem_i) < 5) begin
            case (int'(elem_i))
                0: wrm = 8'b0000_0001;
                1: begin len_o = 3'd2; desc_o = 1'b1; wrm = 8'b0000_0010; valm = 8'b0000_0010; end
                2: begin len_o = 3'd5; wrm = 8'b0001_0010; valm = 8'b0001_0001; end
                3: begin len_o = 3'd2; wrm = 8'b0000_0010; valm = 8'b0000_0001; end
                default: begin len_o = 3'd5; wrm = 8'b0001_0010; valm = 8'b0000_1110; end
            endcase
        end else if (!alg_i[1]) begin
            last_o = 1'b1;
        end else begin
            tab = 1'b0;
            if (k >= 2 * NBG) begin
                last_o = 1'b1;
                bg_o   = BG_IDX_W'(NBG);
            end else if (k % 2 == 0) begin
                len_o = 3'd4;
                case (op_i)
                    3'd0:    bg_o = BG_IDX_W'(pr);
                    3'd1:    begin wr_o = 1'b1; bg_o = BG_IDX_W'(pr + 1); end
                    3'd2:    begin wr_o = 1'b1; inv_o = 1'b1; bg_o = BG_IDX_W'(pr + 1); end
                    default: begin inv_o = 1'b1; bg_o = BG_IDX_W'(pr + 1); end
                endcase
            end else begin
                len_o = 3'd3;
                case (op_i)
                    3'd0:    begin inv_o = 1'b1; bg_o = BG_IDX_W'(pr + 1); end
                    3'd1:    begin wr_o = 1'b1; bg_o = BG_IDX_W'(pr + 1); end
                    default: bg_o = BG_IDX_W'(pr + 1);
                endcase
            end
        end
        if (tab) begin
            wr_o  = wrm[op_i];
            inv_o = valm[op_i];
        end
    end
endmodule

// File: rtl/march_bg_pattern.sv
module march_bg_pattern
    import march_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [BG_IDX_W-1:0] bg_i,
    input  logic                inv_i,
    output logic [DATA_W-1:0]   data_o
);
    logic [DATA_W-1:0] base;

    always_comb begin
        for (int j = 0; j < DATA_W; j++) begin
            if (bg_i == '0) base[j] = 1'b0;
            else            base[j] = 1'(j >> (int'(bg_i) - 1));
        end
        data_o = inv_i ? ~base : base;
    end
endmodule

// File: rtl/march_resp_check.sv
module march_resp_check #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              req_re_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pexp;
        logic              fail;
        logic [ADDR_W-1:0] faddr;
    } chk_s;

    chk_s q, d;
    logic mism;

    always_comb begin
        d       = q;
        d.pend  = req_re_i;
        d.paddr = req_addr_i;
        d.pexp  = req_exp_i;
        mism    = q.pend && (rdata_i != q.pexp);
        if (clear_i) begin
            d.fail  = 1'b0;
            d.faddr = '0;
        end else if (mism && !q.fail) begin
            d.fail  = 1'b1;
            d.faddr = q.paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fail_o      = q.fail;
    assign fail_addr_o = q.faddr;

    p_mismatch_sets_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && (rdata_i != q.pexp) && !clear_i) |=> fail_o);
    p_first_addr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clear_i) |=> (fail_o && $stable(fail_addr_o)));
endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        alg_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int N      = 1 << ADDR_W;
    localparam int NBG    = (DATA_W > 1) ? $clog2(DATA_W) : 0;
    localparam int ELEM_W = $clog2(2 * NBG + 7);
    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(N - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        alg;
        logic [ELEM_W-1:0] elem;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              re;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } seq_s;

    seq_s q, d;

    // current-element view
    logic [2:0]          cur_len;
    logic                cur_desc, cur_last, cur_wr, cur_inv;
    logic [BG_IDX_W-1:0] cur_bg;
    // next-cursor view
    logic [1:0]          nx_alg;
    logic [ELEM_W-1:0]   nx_elem;
    logic [2:0]          nx_op, nx_len;
    logic [ADDR_W-1:0]   nx_addr;
    logic                nx_new, nx_issue, nx_drain, accept;
    logic                nx_desc, nx_last, nx_wr, nx_inv;
    logic [BG_IDX_W-1:0] nx_bg;
    logic [DATA_W-1:0]   nx_pat;

    march_elem_decode #(.ELEM_W(ELEM_W), .NBG(NBG)) u_dec_cur (
        .alg_i(q.alg), .elem_i(q.elem), .op_i(q.op),
        .len_o(cur_len), .desc_o(cur_desc), .last_o(cur_last),
        .wr_o(cur_wr), .inv_o(cur_inv), .bg_o(cur_bg)
    );

    march_elem_decode #(.ELEM_W(ELEM_W), .NBG(NBG)) u_dec_nxt (
        .alg_i(nx_alg), .elem_i(nx_elem), .op_i(nx_op),
        .len_o(nx_len), .desc_o(nx_desc), .last_o(nx_last),
        .wr_o(nx_wr), .inv_o(nx_inv), .bg_o(nx_bg)
    );

    march_bg_pattern #(.DATA_W(DATA_W)) u_pat (
        .bg_i(nx_bg), .inv_i(nx_inv), .data_o(nx_pat)
    );

    // cursor advance: op -> address -> element
    always_comb begin
        nx_alg   = q.alg;
        nx_elem  = q.elem;
        nx_op    = q.op;
        nx_addr  = q.addr;
        nx_new   = 1'b0;
        nx_issue = 1'b0;
        nx_drain = 1'b0;
        accept   = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                accept   = 1'b1;
                nx_alg   = alg_sel;
                nx_elem  = '0;
                nx_op    = '0;
                nx_new   = 1'b1;
                nx_issue = 1'b1;
            end
            ST_RUN: begin
                if (q.op != cur_len - 3'd1) begin
                    nx_op    = q.op + 3'd1;
                    nx_issue = 1'b1;
                end else if (q.addr != (cur_desc ? '0 : ADDR_TOP)) begin
                    nx_op    = '0;
                    nx_addr  = cur_desc ? q.addr - ADDR_W'(1) : q.addr + ADDR_W'(1);
                    nx_issue = 1'b1;
                end else if (cur_last) begin
                    nx_drain = 1'b1;
                end else begin
                    nx_elem  = q.elem + ELEM_W'(1);
                    nx_op    = '0;
                    nx_new   = 1'b1;
                    nx_issue = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.alg  = nx_alg;
        d.elem = nx_elem;
        d.op   = nx_op;
        d.addr = nx_new ? (nx_desc ? ADDR_TOP : '0) : nx_addr;
        d.we   = nx_issue & nx_wr;
        d.re   = nx_issue & ~nx_wr;
        if (nx_issue) d.wdata = nx_pat;
        case (q.st)
            ST_IDLE:  if (accept) d.st = ST_RUN;
            ST_RUN:   if (nx_drain) d.st = ST_DRAIN;
            ST_DRAIN: begin d.st = ST_IDLE; d.done = 1'b1; end
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    march_resp_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .req_re_i(q.re), .req_addr_i(q.addr), .req_exp_i(q.wdata),
        .rdata_i(mem_rdata), .fail_o(fail), .fail_addr_o(fail_addr)
    );

    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign mem_we    = q.we;
    assign mem_re    = q.re;
    assign done      = q.done;

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !(mem_we || mem_re));
    p_one_op_per_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> (mem_we ^ mem_re));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_alg_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.alg));
endmodule

// File: tb/sim_march_bist_ctrl.sv
`timescale 1ns/1ps
module sim_march_bist_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int NB = 3;   // ceil(log2 8)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    alg_sel = 2'd0;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_we, mem_re, done, fail;

    always #5 clk = ~clk;

    march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // RAM model with injectable faults: 0 none, 1 stuck-at-1 bit3 @6,
    // 2 up-write bit0 @2 flips bit0 @5, 3 short bits0/1 @11, 4 up-write bit0 @9 flips bit0 @3
    logic [DW-1:0] ram [N];
    logic [DW-1:0] wv;
    int fmode = 0;
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= ram[mem_addr];
        if (mem_we) begin
            wv = mem_wdata;
            if (fmode == 1 && mem_addr == 6) wv[3] = 1'b1;
            if (fmode == 3 && mem_addr == 11) wv[1:0] = {2{wv[0] & wv[1]}};
            ram[mem_addr] <= wv;
            if (fmode == 2 && mem_addr == 2 && !ram[2][0] && wv[0]) ram[5][0] <= ~ram[5][0];
            if (fmode == 4 && mem_addr == 9 && !ram[9][0] && wv[0]) ram[3][0] <= ~ram[3][0];
        end
    end

    int n_tests = 0, n_fail = 0;
    int nwr, nrd, opn;
    int sp_at [3];
    int sp_addr [3], sp_we [3], sp_dat [3];

    always @(negedge clk) begin
        if (mem_we || mem_re) begin
            for (int s = 0; s < 3; s++)
                if (opn == sp_at[s]) begin
                    sp_addr[s] = int'(mem_addr);
                    sp_we[s]   = int'(mem_we);
                    sp_dat[s]  = int'(mem_wdata);
                end
            if (mem_we) nwr++; else nrd++;
            opn++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] alg, input bit glitch, output int cyc);
        bit seen = 1'b0;
        @(negedge clk);
        nwr = 0; nrd = 0; opn = 0;
        start = 1'b1; alg_sel = alg;
        @(negedge clk);
        start = 1'b0; alg_sel = 2'd0;
        cyc = 0;
        while (!seen && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (glitch && cyc == 10) begin start = 1'b1; alg_sel = 2'd1; end
            else start = 1'b0;
            if (done) seen = 1'b1;
        end
        if (!seen) chk("R8 watchdog run", cyc, -1);
        @(negedge clk);
        chk("R8 done lasts one cycle", int'(done), 0);
    endtask

    function automatic int bgw(input int b);
        int v = 0;
        for (int j = 0; j < DW; j++) if (b > 0 && ((j >> (b - 1)) & 1) == 1) v |= (1 << j);
        return v;
    endfunction

    task automatic ram_all(input string req, input int val);
        int bad = 0;
        for (int a = 0; a < N; a++) if (int'(ram[a]) != val) bad++;
        chk(req, bad, 0);
    endtask

    initial begin
        int cyc;
        for (int a = 0; a < N; a++) ram[a] = '0;
        sp_at = '{-1, -1, -1};
        repeat (3) @(negedge clk);
        chk("R9 done after reset", int'(done), 0);
        chk("R9 fail after reset", int'(fail), 0);
        chk("R9 strobes idle after reset", int'(mem_we | mem_re), 0);
        chk("R9 fail_addr after reset", int'(fail_addr), 0);
        rst_n = 1'b1;

        // R2 March Y clean, with element-boundary spots for R5
        sp_at = '{0, 4 * N, 4 * N + 1};
        run(2'd0, 1'b0, cyc);
        chk("R2 R8 March Y length", cyc, 8 * N + 1);
        chk("R2 writes", nwr, 3 * N);
        chk("R2 reads", nrd, 5 * N);
        chk("R7 clean pass", int'(fail), 0);
        chk("R5 first op addr", sp_addr[0], 0);
        chk("R5 first op is write", sp_we[0], 1);
        chk("R5 descending element starts at top", sp_addr[1], N - 1);
        chk("R6 expected data on read", sp_dat[1], 255);
        chk("R5 same address for next op", sp_addr[2], N - 1);
        ram_all("R2 final contents zero", 0);

        // R3 March LR clean
        sp_at = '{N, N + 1, 3 * N};
        run(2'd1, 1'b0, cyc);
        chk("R3 R8 March LR length", cyc, 16 * N + 1);
        chk("R3 writes", nwr, 7 * N);
        chk("R3 reads", nrd, 9 * N);
        chk("R5 LR descending start", sp_addr[0], N - 1);
        chk("R5 LR second op same addr", sp_addr[1], N - 1);
        chk("R5 LR third element ascending start", sp_addr[2], 0);
        chk("R7 LR clean pass", int'(fail), 0);

        // R4 backgrounds, with an ignored start mid-run (R1)
        sp_at = '{15 * N, 15 * N + 1, 15 * N + 2};
        run(2'd2, 1'b1, cyc);
        chk("R4 R1 background run length", cyc, (16 + 7 * NB) * N + 1);
        chk("R4 writes", nwr, (7 + 3 * NB) * N);
        chk("R4 reads", nrd, (9 + 4 * NB) * N);
        chk("R4 first background read value", sp_dat[0], 0);
        chk("R4 first background write", sp_dat[1], bgw(1));
        chk("R4 complement write", sp_dat[2], bgw(1) ^ 255);
        ram_all("R4 final contents last background", bgw(NB));
        chk("R4 clean pass", int'(fail), 0);

        run(2'd3, 1'b0, cyc);
        chk("R1 code 3 selects background run", cyc, (16 + 7 * NB) * N + 1);

        // R7 stuck-at, then clean run clears flags
        fmode = 1;
        run(2'd1, 1'b0, cyc);
        chk("R7 stuck-at flagged", int'(fail), 1);
        chk("R7 stuck-at address", int'(fail_addr), 6);
        fmode = 0;
        run(2'd0, 1'b0, cyc);
        chk("R7 flags cleared by start", int'(fail), 0);
        chk("R7 address cleared by start", int'(fail_addr), 0);

        // coupling faults, aggressor below and above victim
        fmode = 2;
        run(2'd0, 1'b0, cyc);
        chk("R5 R7 coupling up victim flagged", int'(fail), 1);
        chk("R5 R7 coupling up victim address", int'(fail_addr), 5);
        fmode = 4;
        run(2'd0, 1'b0, cyc);
        chk("R5 R7 coupling down victim flagged", int'(fail), 1);
        chk("R5 R7 coupling down victim address", int'(fail_addr), 3);

        // intra-word short: missed without backgrounds, caught with them
        fmode = 3;
        run(2'd1, 1'b0, cyc);
        chk("R4 short missed by plain LR", int'(fail), 0);
        run(2'd2, 1'b0, cyc);
        chk("R4 short caught with backgrounds", int'(fail), 1);
        chk("R4 short address", int'(fail_addr), 11);
        fmode = 0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL R8 global watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule